// File: doc/BRIEF.md
# Serial Configuration Loader Sequencer

This block loads a bitstream into a programmable target device over a slave-serial configuration port. A one-cycle start request begins a fixed sequence. The block drives the active-low program line low, then waits for the target's init line to fall. It releases the program line and waits for init to rise again. After that it shifts the configuration bytes out on a data/clock pin pair and finally waits for the target's done line. Each of the three waits has its own timeout and its own error code.

Configuration bytes arrive on a valid/ready stream, and the byte marked last ends the shifting phase. Each byte is sent most significant bit first. A bit is placed on the data pin while the clock is low, and the clock then rises so the target samples on that edge. The block holds the outcome until the next start: a success flag or a 2-bit error code.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset and whenever the block is idle (busy low), progN, cclkOut and dataOut are all 1. After reset, busy, success and errCode are 0.
- R2: A start pulse seen while idle makes busy 1 and progN 0 from the next cycle, with cclkOut and dataOut still 1. progN stays 0 until initIn is sampled low.
- R3: If initIn is still high TIMEOUT_TICKS*TICK_CYCLES cycles after program is asserted, the block returns to idle with errCode 2'd1. busy is high for exactly TIMEOUT_TICKS*TICK_CYCLES+1 cycles. If initIn is low in the cycle the window expires, it wins over the timeout.
- R4: Once initIn is sampled low, progN returns to 1 on the next cycle. If initIn then fails to return high within the timeout window, the block goes idle with errCode 2'd2.
- R5: After initIn is high again, bytes are taken from the stream in order (a transfer happens when byteValid and byteReady are both 1). Each byte is sent as 8 bits, most significant bit first. byteReady is 1 only while shifting with no byte in flight.
- R6: For each bit, dataOut carries the bit while cclkOut is low for HALF_CYCLES cycles. cclkOut then rises with data held for HALF_CYCLES cycles. progN is 1 at every rising edge of cclkOut.
- R7: Between bytes, and while the stream stalls, cclkOut and dataOut rest at 1.
- R8: After the byte flagged last has been shifted, the block waits for doneIn. doneIn high ends the run with success 1 and errCode 0. A timeout ends it with success 0 and errCode 2'd3.
- R9: A start pulse while busy is ignored: the running sequence and its shifted data are unaffected, and progN is not asserted again.
- R10: success and errCode hold their value while idle, until the next accepted start clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request to begin a configuration run |
| byteValid | input | 1 | Stream byte available |
| byteData | input | 8 | Stream byte |
| byteLast | input | 1 | Marks the final byte of the stream |
| byteReady | output | 1 | Block accepts the offered byte this cycle |
| initIn | input | 1 | Target init handshake line |
| doneIn | input | 1 | Target done line |
| progN | output | 1 | Active-low program line to the target |
| cclkOut | output | 1 | Configuration clock to the target |
| dataOut | output | 1 | Configuration data to the target |
| busy | output | 1 | A run is in progress |
| success | output | 1 | Last run completed with done seen |
| errCode | output | 2 | Last failure: 0 none, 1 init never fell, 2 init never rose, 3 done never rose |

## Verification
The init-low wait can see the target's response in the same cycle as its timeout expiry. The bench provokes this by holding init low after exactly TIMEOUT_TICKS*TICK_CYCLES cycles of program assertion. It then expects the run to continue to success rather than abort with code 1. A second collision puts a new start pulse in the middle of the bit shifting. The scoreboard must still see every byte intact, progN must stay high at every clock rise, and the run must end successfully.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_INIT_LOW  = 2'd1;
  localparam logic [1:0] ERR_INIT_HIGH = 2'd2;
  localparam logic [1:0] ERR_DONE      = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_INIT_HI,
    S_SHIFT,
    S_DONE
  } loaderState_t;

  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic shiftEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/cfg_loader_timer.sv
module cfg_loader_timer #(
  parameter int TICK_CYCLES   = 16,
  parameter int TIMEOUT_TICKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic run,
  output logic timedOut
);
  localparam int PW = $clog2(TICK_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);
  localparam logic [TW-1:0] TICK_LIM = TW'(TIMEOUT_TICKS);

  logic [PW-1:0] preCnt;
  logic [TW-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (clr) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (run && tickCnt != TICK_LIM) begin
      if (preCnt == PRE_LAST) begin
        preCnt  <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign timedOut = (tickCnt == TICK_LIM);
endmodule

// File: rtl/cfg_loader_shift.sv
module cfg_loader_shift
  import cfg_loader_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         byteValid,
  input  logic [7:0]   byteData,
  input  logic         byteLast,
  output logic         byteReady,
  output logic         shiftFinish,
  output logic         cclkOut,
  output logic         dataOut
);
  localparam int HW = $clog2(HALF_CYCLES + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYCLES - 1);

  logic [7:0]    shiftReg;
  logic [3:0]    bitsLeft;
  logic [HW-1:0] halfCnt;
  logic          phaseHigh;
  logic          lastReg;
  logic          cclkReg;
  logic          dataReg;
  logic          halfEnd;
  logic          bitEnd;

  assign byteReady   = strobes.shiftEn && (bitsLeft == 4'd0);
  assign halfEnd     = (bitsLeft != 4'd0) && (halfCnt == HALF_LAST);
  assign bitEnd      = halfEnd && phaseHigh;
  assign shiftFinish = bitEnd && (bitsLeft == 4'd1) && lastReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitsLeft  <= '0;
      halfCnt   <= '0;
      phaseHigh <= 1'b0;
      lastReg   <= 1'b0;
      cclkReg   <= 1'b1;
      dataReg   <= 1'b1;
    end else if (byteReady && byteValid) begin
      shiftReg  <= byteData;
      bitsLeft  <= 4'd8;
      halfCnt   <= '0;
      phaseHigh <= 1'b0;
      lastReg   <= byteLast;
      cclkReg   <= 1'b0;
      dataReg   <= byteData[7];
    end else if (bitsLeft != 4'd0) begin
      if (!halfEnd) begin
        halfCnt <= halfCnt + 1'b1;
      end else if (!phaseHigh) begin
        halfCnt   <= '0;
        phaseHigh <= 1'b1;
        cclkReg   <= 1'b1;
      end else begin
        halfCnt   <= '0;
        phaseHigh <= 1'b0;
        bitsLeft  <= bitsLeft - 1'b1;
        shiftReg  <= {shiftReg[6:0], 1'b0};
        if (bitsLeft != 4'd1) begin
          cclkReg <= 1'b0;
          dataReg <= shiftReg[6];
        end else begin
          dataReg <= 1'b1;
        end
      end
    end
  end

  assign cclkOut = cclkReg;
  assign dataOut = dataReg;
endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         initIn,
  input  logic         doneIn,
  input  logic         timedOut,
  input  logic         shiftFinish,
  output ctrlStrobes_t strobes,
  output logic         progN,
  output logic         busy,
  output logic         success,
  output logic [1:0]   errCode
);
  loaderState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      progN   <= 1'b1;
      success <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      case (state)
        S_IDLE: if (startPulse) begin
          state   <= S_PROG;
          progN   <= 1'b0;
          success <= 1'b0;
          errCode <= ERR_NONE;
        end
        S_PROG: if (!initIn) begin
          state <= S_INIT_HI;
          progN <= 1'b1;
        end else if (timedOut) begin
          state   <= S_IDLE;
          progN   <= 1'b1;
          errCode <= ERR_INIT_LOW;
        end
        S_INIT_HI: if (initIn) begin
          state <= S_SHIFT;
        end else if (timedOut) begin
          state   <= S_IDLE;
          errCode <= ERR_INIT_HIGH;
        end
        S_SHIFT: if (shiftFinish) state <= S_DONE;
        S_DONE: if (doneIn) begin
          state   <= S_IDLE;
          success <= 1'b1;
        end else if (timedOut) begin
          state   <= S_IDLE;
          errCode <= ERR_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.timerRun = (state == S_PROG) || (state == S_INIT_HI) || (state == S_DONE);
    strobes.timerClr = !strobes.timerRun || ((state == S_PROG) && !initIn);
    strobes.shiftEn  = (state == S_SHIFT);
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int HALF_CYCLES   = 2,
  parameter int TICK_CYCLES   = 16,
  parameter int TIMEOUT_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       byteLast,
  output logic       byteReady,
  input  logic       initIn,
  input  logic       doneIn,
  output logic       progN,
  output logic       cclkOut,
  output logic       dataOut,
  output logic       busy,
  output logic       success,
  output logic [1:0] errCode
);
  ctrlStrobes_t strobes;
  logic         timedOut;
  logic         shiftFinish;

  cfg_loader_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .initIn(initIn),
    .doneIn(doneIn), .timedOut(timedOut), .shiftFinish(shiftFinish),
    .strobes(strobes), .progN(progN), .busy(busy), .success(success),
    .errCode(errCode)
  );

  cfg_loader_timer #(.TICK_CYCLES(TICK_CYCLES), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rstN(rstN), .clr(strobes.timerClr), .run(strobes.timerRun),
    .timedOut(timedOut)
  );

  cfg_loader_shift #(.HALF_CYCLES(HALF_CYCLES)) u_shift (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteValid(byteValid),
    .byteData(byteData), .byteLast(byteLast), .byteReady(byteReady),
    .shiftFinish(shiftFinish), .cclkOut(cclkOut), .dataOut(dataOut)
  );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       byteReady,
  input logic       progN,
  input logic       cclkOut,
  input logic       dataOut,
  input logic       busy,
  input logic       success,
  input logic [1:0] errCode
);
  // R1: idle pins rest high
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (progN && cclkOut && dataOut));

  // R2: a run begins with program asserted
  p_prog_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !progN);

  // R5: stream accepted only while running with program released
  p_ready_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> (busy && progN));

  // R6: program high at every configuration clock rise
  p_prog_high_clk_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cclkOut) |-> progN);

  // R8: each run ends with exactly one outcome
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (success != (errCode != 2'd0)));

  // R9: once released during a run, program is not asserted again
  p_no_reprog_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && progN) |=> progN);

  // R10: outcome held while idle
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> ($stable(errCode) && $stable(success)));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteReady(byteReady),
  .progN(progN), .cclkOut(cclkOut), .dataOut(dataOut), .busy(busy),
  .success(success), .errCode(errCode)
);

// File: tb/serial_cfg_loader_tb.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb;
  localparam int HALF_CYCLES   = 2;
  localparam int TICK_CYCLES   = 16;
  localparam int TIMEOUT_TICKS = 4;
  localparam int WINDOW = TICK_CYCLES * TIMEOUT_TICKS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteLast = 1'b0;
  logic byteReady;
  logic initIn = 1'b1;
  logic doneIn = 1'b0;
  logic progN, cclkOut, dataOut, busy, success;
  logic [1:0] errCode;

  int tests = 0;
  int fails = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] rxByte = '0;
  int rxBits = 0;
  int rxCount = 0;
  int lowCnt = 0;
  int busyCnt = 0;

  always #4 clk = ~clk;

  serial_cfg_loader #(.HALF_CYCLES(HALF_CYCLES), .TICK_CYCLES(TICK_CYCLES),
                      .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
    .byteData(byteData), .byteLast(byteLast), .byteReady(byteReady),
    .initIn(initIn), .doneIn(doneIn), .progN(progN), .cclkOut(cclkOut),
    .dataOut(dataOut), .busy(busy), .success(success), .errCode(errCode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busy) busyCnt++;
    if (!cclkOut) lowCnt++;
  end

  // monitor: rebuilds bytes at each rising clock and pops the scoreboard
  always @(posedge cclkOut) begin
    if (monOn) begin
      check(progN == 1'b1, "R6", "progN at clock rise", int'(progN), 1);
      check(lowCnt == HALF_CYCLES, "R6", "clock low length", lowCnt, HALF_CYCLES);
      rxByte = {rxByte[6:0], dataOut};
      rxBits++;
      if (rxBits == 8) begin
        rxBits = 0;
        rxCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected byte", int'(rxByte), -1);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(rxByte == e, "R5", "byte MSB first", int'(rxByte), int'(e));
        end
      end
    end
    lowCnt = 0;
  end

  task automatic pulseStart(input bit expectIdle);
    @(negedge clk);
    startPulse = 1'b1;
    busyCnt = 0;
    @(negedge clk);
    startPulse = 1'b0;
    if (expectIdle) begin
      check(progN == 1'b0 && busy == 1'b1, "R2", "progN/busy after start",
            int'({progN, busy}), 1);
      check(cclkOut && dataOut, "R2", "clk/data high at start",
            int'({cclkOut, dataOut}), 3);
      check(errCode == 2'd0 && !success, "R10", "result cleared by start",
            int'({success, errCode}), 0);
    end
  endtask

  task automatic target(input int dLow, input int dHigh, input int dDone,
                        input int nBytes);
    while (progN) @(negedge clk);
    if (dLow < 0) begin
      while (busy) @(negedge clk);
      return;
    end
    repeat (dLow) @(negedge clk);
    check(progN == 1'b0, "R2", "progN held until init low", int'(progN), 0);
    initIn = 1'b0;
    @(negedge clk);
    check(progN == 1'b1, "R4", "progN released after init low", int'(progN), 1);
    if (dHigh < 0) begin
      while (busy) @(negedge clk);
      initIn = 1'b1;
      return;
    end
    repeat (dHigh) @(negedge clk);
    initIn = 1'b1;
    while (busy && rxCount < nBytes) @(negedge clk);
    if (dDone >= 0) begin
      repeat (dDone) @(negedge clk);
      doneIn = 1'b1;
    end
    while (busy) @(negedge clk);
    doneIn = 1'b0;
  endtask

  task automatic driver(input int nBytes, input logic [7:0] seed, input int gap);
    for (int i = 0; i < nBytes; i++) begin
      logic [7:0] b;
      b = seed ^ 8'(i * 37);
      expQ.push_back(b);
      byteValid = 1'b1;
      byteData  = b;
      byteLast  = (i == nBytes - 1);
      while (busy && !byteReady) @(negedge clk);
      if (!busy) break;
      @(negedge clk);
      byteValid = 1'b0;
      while (busy && byteReady == 1'b0 && cclkOut == 1'b0) @(negedge clk);
      while (busy && !byteReady) @(negedge clk);
      for (int g = 0; g < gap; g++) begin
        check(cclkOut && dataOut, "R7", "rest high during stall",
              int'({cclkOut, dataOut}), 3);
        @(negedge clk);
      end
    end
    byteValid = 1'b0;
    byteLast  = 1'b0;
  endtask

  task automatic midStart();
    while (busy && rxCount < 1) @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic runSeq(input int dLow, input int dHigh, input int dDone,
                        input int nBytes, input logic [7:0] seed, input int gap,
                        input bit doMid, input string req, input logic [1:0] expErr);
    expQ.delete();
    rxCount = 0;
    rxBits = 0;
    pulseStart(1'b1);
    fork
      target(dLow, dHigh, dDone, nBytes);
      driver(nBytes, seed, gap);
      if (doMid) midStart();
    join
    while (busy) @(negedge clk);
    check(errCode == expErr, req, "error code", int'(errCode), int'(expErr));
    check(success == (expErr == 2'd0), req, "success flag", int'(success),
          int'(expErr == 2'd0));
    check(progN && cclkOut && dataOut, "R1", "idle pins after run",
          int'({progN, cclkOut, dataOut}), 7);
    if (expErr == 2'd0)
      check(expQ.size() == 0 && rxCount == nBytes, "R5", "all bytes shifted",
            rxCount, nBytes);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(progN && cclkOut && dataOut, "R1", "pins high in reset",
          int'({progN, cclkOut, dataOut}), 7);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !success && errCode == 2'd0, "R1", "reset outcome",
          int'({busy, success, errCode}), 0);
    monOn = 1'b1;

    // normal run, three bytes, stream stalls between bytes
    runSeq(5, 5, 3, 3, 8'hA5, 4, 1'b0, "R8", 2'd0);

    // init never falls
    runSeq(-1, 0, 0, 0, 8'h00, 0, 1'b0, "R3", 2'd1);
    check(busyCnt == WINDOW + 1, "R3", "busy length before abort", busyCnt, WINDOW + 1);
    repeat (10) @(negedge clk);
    check(errCode == 2'd1 && !success, "R10", "error held while idle",
          int'(errCode), 1);

    // init falls exactly in the expiry cycle: response wins
    runSeq(WINDOW, 2, 1, 2, 8'h3C, 0, 1'b0, "R3", 2'd0);

    // init never rises again
    runSeq(3, -1, 0, 0, 8'h00, 0, 1'b0, "R4", 2'd2);

    // done never rises
    runSeq(2, 2, -1, 1, 8'h81, 0, 1'b0, "R8", 2'd3);

    // start pulse in the middle of shifting is ignored
    runSeq(4, 4, 2, 3, 8'h5E, 1, 1'b1, "R9", 2'd0);

    // back-to-back bytes, done already high during shift
    runSeq(0, 0, 0, 4, 8'hF0, 0, 1'b0, "R5", 2'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule